// File: doc/BRIEF.md
# Bus Protection Handshake Sequencer

This block isolates a power domain from the interconnect before the domain is switched off, and lifts that isolation again once power is back. It holds two short step tables as parameters. One table is used when the domain goes down and the other when it comes back up. After a start pulse the block walks the chosen table. For each step it raises a write strobe towards one enable target and presents that step's mask. If the step also names a ready target, the block then polls that target's ready bits until every masked bit is set.

A poll happens once per poll interval, and a parameterised divider derives that interval from the system clock. If a poll budget runs out, the block gives up on the whole walk and reports a timeout with a fixed error code. The register decode and the real interconnect sit outside the block. The enable strobes and ready lanes stand in for them.

Top module: `bps_seq`

## Requirements
- R1: After an accepted start, steps are issued strictly in table order from index 0 up to the selected table's configured step count. With no timeout, exactly that many writes occur.
- R2: Each step writes before any ready check. For one cycle, exactly one bit of `en_wr_o` is high, the bit at the step's enable id, and `en_mask_o` carries the step's mask.
- R3: A step without a ready target is followed by the next step's write in the very next cycle. If it is the last step, `done_o` rises in the next cycle.
- R4: A step with a ready target passes only when (ready lane & mask) == mask, where lane g is `rdy_i[g*MASK_W +: MASK_W]`. Ready bits outside the mask do not matter. A pass on the first poll puts the next write two cycles after the current one.
- R5: Polls happen in the cycle after the write and then every `TICK_CYC` cycles. After `POLLS` failed polls, `done_o` rises exactly 2+(POLLS-1)*TICK_CYC cycles after that step's write. Ready that is present for the final poll still counts as a pass.
- R6: After a timeout, no further step is written. `timeout_o` is 1 and `err_code_o` equals `ERR_CODE` (default 25). Without a timeout, `err_code_o` is 0.
- R7: `dir_i`=0 selects the power-down table and `dir_i`=1 selects the power-up table. Each table entry is {enable id, mask, ready-present, ready id}, with the ready id in the least significant bits. The defaults are: power-down (0,0x0F,1,1),(2,0x30,0,-),(3,0xC1,1,3); power-up (1,0x5A,0,-),(0,0x81,1,2).
- R8: `done_o` is a one-cycle pulse at the end of every walk, whether it succeeded or aborted. `timeout_o` holds until the next accepted start and reads 0 in the cycle after it.
- R9: A start pulse while `busy_o` is high is ignored. The running walk, including its table choice, is unchanged.
- R10: During and after reset, before any start, `busy_o`, `done_o`, `timeout_o`, `en_wr_o` and `err_code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| dir_i | input | 1 | Table select: 0 power-down, 1 power-up |
| en_wr_o | output | N_TGT | One-hot write strobe per enable target |
| en_mask_o | output | MASK_W | Mask written with the strobe |
| rdy_i | input | N_TGT*MASK_W | Ready lanes, one per target |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| timeout_o | output | 1 | Last walk aborted on a ready timeout |
| err_code_o | output | ERR_W | Error code, ERR_CODE after a timeout |

## Verification
The hardest case to reach is ready arriving at the exact edge of the poll budget. There, one cycle separates a pass on the final poll from an abort. The bench handles this directly. It clears the ready lane of the first waited step, finds the write cycle at the ports, and then raises the lane either in the final poll cycle or one cycle after it. It expects a completed walk in the first case and a timeout in the second. Random ready patterns with single missing mask bits make aborts land on different steps of both tables.

// File: rtl/bps_pkg.sv
package bps_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_WAIT  = 2'd2
   } bps_state_e;

   function automatic int unsigned bps_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/bps_tick_div.sv
module bps_tick_div #(
   parameter int unsigned TICK_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic tick_o
);
   localparam int unsigned CW = bps_pkg::bps_w(TICK_CYC);
   localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

   logic [CW-1:0] cnt_q;

   if (TICK_CYC < 1) begin : g_bad_tick
      $error("TICK_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clr_i)      cnt_q <= '0;
      else if (en_i)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   assign tick_o = en_i && (cnt_q == '0);

   AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R5
endmodule

// File: rtl/bps_step_rom.sv
module bps_step_rom #(
   parameter int unsigned N_TGT     = 4,
   parameter int unsigned MASK_W    = 8,
   parameter int unsigned MAX_STEPS = 4,
   parameter int unsigned SET_STEPS = 3,
   parameter int unsigned CLR_STEPS = 2,
   parameter int unsigned EW        = 13,
   parameter logic [MAX_STEPS*EW-1:0] SET_ROM = '0,
   parameter logic [MAX_STEPS*EW-1:0] CLR_ROM = '0
) (
   input  logic                                  dir_i,
   input  logic [bps_pkg::bps_w(MAX_STEPS)-1:0]  idx_i,
   output logic [bps_pkg::bps_w(N_TGT)-1:0]      en_id_o,
   output logic [MASK_W-1:0]                     mask_o,
   output logic                                  has_rdy_o,
   output logic [bps_pkg::bps_w(N_TGT)-1:0]      rdy_id_o,
   output logic                                  last_o
);
   localparam int unsigned IW = bps_pkg::bps_w(N_TGT);
   localparam int unsigned XW = bps_pkg::bps_w(MAX_STEPS);

   if (EW != 2*IW + MASK_W + 1) begin : g_bad_ew
      $error("entry width does not match id and mask widths");
   end
   if (SET_STEPS < 1 || SET_STEPS > MAX_STEPS) begin : g_bad_set
      $error("SET_STEPS out of range");
   end
   if (CLR_STEPS < 1 || CLR_STEPS > MAX_STEPS) begin : g_bad_clr
      $error("CLR_STEPS out of range");
   end

   logic [EW-1:0] ent;
   logic [XW-1:0] last_idx;

   always_comb begin
      ent      = dir_i ? CLR_ROM[idx_i*EW +: EW] : SET_ROM[idx_i*EW +: EW];
      last_idx = dir_i ? XW'(CLR_STEPS - 1) : XW'(SET_STEPS - 1);
   end

   assign rdy_id_o  = ent[IW-1:0];
   assign has_rdy_o = ent[IW];
   assign mask_o    = ent[IW+1 +: MASK_W];
   assign en_id_o   = ent[IW+1+MASK_W +: IW];
   assign last_o    = (idx_i == last_idx);
endmodule

// File: rtl/bps_rdy_check.sv
module bps_rdy_check #(
   parameter int unsigned N_TGT  = 4,
   parameter int unsigned MASK_W = 8
) (
   input  logic [N_TGT*MASK_W-1:0]             rdy_i,
   input  logic [bps_pkg::bps_w(N_TGT)-1:0]    sel_i,
   input  logic [MASK_W-1:0]                   mask_i,
   output logic                                ok_o
);
   logic [MASK_W-1:0] lane [N_TGT];

   for (genvar g = 0; g < N_TGT; g++) begin : g_lane
      assign lane[g] = rdy_i[g*MASK_W +: MASK_W];
   end

   assign ok_o = ((lane[sel_i] & mask_i) == mask_i);
endmodule

// File: rtl/bps_seq.sv
module bps_seq #(
   parameter int unsigned N_TGT     = 4,
   parameter int unsigned MASK_W    = 8,
   parameter int unsigned MAX_STEPS = 4,
   parameter int unsigned SET_STEPS = 3,
   parameter int unsigned CLR_STEPS = 2,
   parameter logic [MAX_STEPS*(2*$clog2(N_TGT)+MASK_W+1)-1:0] SET_ROM =
      {13'd0, {2'd3, 8'hC1, 1'b1, 2'd3}, {2'd2, 8'h30, 1'b0, 2'd0}, {2'd0, 8'h0F, 1'b1, 2'd1}},
   parameter logic [MAX_STEPS*(2*$clog2(N_TGT)+MASK_W+1)-1:0] CLR_ROM =
      {13'd0, 13'd0, {2'd0, 8'h81, 1'b1, 2'd2}, {2'd1, 8'h5A, 1'b0, 2'd0}},
   parameter int unsigned TICK_CYC  = 50,
   parameter int unsigned POLLS     = 500,
   parameter int unsigned ERR_W     = 5,
   parameter int unsigned ERR_CODE  = 25
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      dir_i,
   output logic [N_TGT-1:0]          en_wr_o,
   output logic [MASK_W-1:0]         en_mask_o,
   input  logic [N_TGT*MASK_W-1:0]   rdy_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic                      timeout_o,
   output logic [ERR_W-1:0]          err_code_o
);
   import bps_pkg::*;

   localparam int unsigned IW = bps_w(N_TGT);
   localparam int unsigned XW = bps_w(MAX_STEPS);
   localparam int unsigned PW = bps_w(POLLS);
   localparam int unsigned EW = 2*IW + MASK_W + 1;
   localparam logic [PW-1:0] P_LAST = PW'(POLLS - 1);

   if (N_TGT < 2) begin : g_bad_tgt
      $error("N_TGT must be at least 2");
   end
   if (POLLS < 1) begin : g_bad_polls
      $error("POLLS must be at least 1");
   end
   if (ERR_CODE == 0 || ERR_CODE >= (1 << ERR_W)) begin : g_bad_err
      $error("ERR_CODE must be nonzero and fit ERR_W");
   end

   bps_state_e     state_q;
   logic [XW-1:0]  idx_q;
   logic [PW-1:0]  pcnt_q;
   logic           dir_q, done_q, to_q;

   logic [IW-1:0]     en_id, rdy_id;
   logic [MASK_W-1:0] mask;
   logic              has_rdy, last, rdy_ok, tick;

   bps_step_rom #(
      .N_TGT(N_TGT), .MASK_W(MASK_W), .MAX_STEPS(MAX_STEPS),
      .SET_STEPS(SET_STEPS), .CLR_STEPS(CLR_STEPS), .EW(EW),
      .SET_ROM(SET_ROM), .CLR_ROM(CLR_ROM)
   ) u_rom (
      .dir_i(dir_q), .idx_i(idx_q), .en_id_o(en_id), .mask_o(mask),
      .has_rdy_o(has_rdy), .rdy_id_o(rdy_id), .last_o(last)
   );

   bps_rdy_check #(.N_TGT(N_TGT), .MASK_W(MASK_W)) u_chk (
      .rdy_i(rdy_i), .sel_i(rdy_id), .mask_i(mask), .ok_o(rdy_ok)
   );

   bps_tick_div #(.TICK_CYC(TICK_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n),
      .clr_i(state_q == ST_WRITE), .en_i(state_q == ST_WAIT), .tick_o(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         pcnt_q  <= '0;
         dir_q   <= 1'b0;
         done_q  <= 1'b0;
         to_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  dir_q   <= dir_i;
                  idx_q   <= '0;
                  to_q    <= 1'b0;
                  state_q <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               pcnt_q <= '0;
               if (has_rdy) begin
                  state_q <= ST_WAIT;
               end else if (last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_WAIT: begin
               if (tick) begin
                  if (rdy_ok) begin
                     if (last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_WRITE;
                     end
                  end else if (pcnt_q == P_LAST) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     to_q    <= 1'b1;
                  end else begin
                     pcnt_q <= pcnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign en_wr_o    = (state_q == ST_WRITE) ? (N_TGT'(1) << en_id) : '0;
   assign en_mask_o  = (state_q == ST_WRITE) ? mask : '0;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign timeout_o  = to_q;
   assign err_code_o = to_q ? ERR_W'(ERR_CODE) : '0;

   AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en_wr_o)); // R2
   AST_IDX_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> idx_q >= $past(idx_q)); // R1
   AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_WAIT |-> pcnt_q <= P_LAST); // R5
   AST_TO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> en_wr_o == '0 && !busy_o); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
   AST_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o && !start_i |=> timeout_o); // R8
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> dir_q == $past(dir_q)); // R9
endmodule

// File: tb/sim_bps_seq.sv
module sim_bps_seq;
   localparam int NT = 4;
   localparam int MW = 8;
   localparam int TK = 3;
   localparam int NP = 5;
   localparam int TO_GAP = 2 + (NP - 1) * TK;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic dir_i = 1'b0;
   logic [NT*MW-1:0] rdy_i = '0;
   logic [NT-1:0] en_wr_o;
   logic [MW-1:0] en_mask_o;
   logic busy_o, done_o, timeout_o;
   logic [4:0] err_code_o;

   always #10 clk = ~clk;

   bps_seq #(.TICK_CYC(TK), .POLLS(NP)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
      .en_wr_o(en_wr_o), .en_mask_o(en_mask_o), .rdy_i(rdy_i),
      .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
      .err_code_o(err_code_o)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nchk = 0, nerr = 0;
   bit logging = 0, got_done = 0;
   int nwr = 0, done_cyc = 0;
   int wr_tgt[8];
   int wr_mask[8];
   int wr_cyc[8];

   function automatic int oh_idx(logic [NT-1:0] v);
      if ($countones(v) != 1) return -1;
      for (int i = 0; i < NT; i++) if (v[i]) return i;
      return -1;
   endfunction

   always @(negedge clk) begin
      if (logging) begin
         if (en_wr_o != '0 && nwr < 8) begin
            wr_tgt[nwr]  = oh_idx(en_wr_o);
            wr_mask[nwr] = int'(en_mask_o);
            wr_cyc[nwr]  = cyc;
            nwr++;
         end
         if (done_o && !got_done) begin
            got_done = 1;
            done_cyc = cyc;
         end
      end
   end

   // Step tables as given in R7
   function automatic int t_cnt(bit d);  return d ? 2 : 3; endfunction
   function automatic int t_tgt(bit d, int k);
      if (d) return (k == 0) ? 1 : 0;
      return (k == 0) ? 0 : (k == 1) ? 2 : 3;
   endfunction
   function automatic int t_mask(bit d, int k);
      if (d) return (k == 0) ? 'h5A : 'h81;
      return (k == 0) ? 'h0F : (k == 1) ? 'h30 : 'hC1;
   endfunction
   function automatic bit t_hr(bit d, int k);
      if (d) return k == 1;
      return k != 1;
   endfunction
   function automatic int t_rid(bit d, int k);
      if (d) return 2;
      return (k == 0) ? 1 : 3;
   endfunction

   function automatic bit step_pass(bit d, int k, logic [NT*MW-1:0] r, int late_off);
      if (!t_hr(d, k)) return 1;
      if (late_off > 0 && k == 0) return late_off <= 1 + (NP - 1) * TK;
      return (int'(r[t_rid(d, k)*MW +: MW]) & t_mask(d, k)) == t_mask(d, k);
   endfunction

   task automatic chk(string req, string what, int act, int expv);
      nchk++;
      if (act != expv) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic run(bit d, logic [NT*MW-1:0] r, int late_off, bit poke, bit timing);
      int exp_n = 0;
      bit exp_to = 0;
      int w = 0;
      for (int k = 0; k < t_cnt(d); k++) begin
         exp_n++;
         if (!step_pass(d, k, r, late_off)) begin exp_to = 1; break; end
      end
      @(negedge clk);
      rdy_i = r; dir_i = d; start_i = 1'b1;
      nwr = 0; got_done = 0; logging = 1;
      @(negedge clk);
      chk("R8", "timeout cleared by start", int'(timeout_o), 0);
      if (poke) dir_i = ~d;       // R9: second start while busy
      else start_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      while (!got_done && w < 3000) begin
         if (late_off > 0 && nwr >= 1 && cyc == wr_cyc[0] + late_off)
            rdy_i[1*MW +: MW] = 8'h0F;
         @(negedge clk);
         w++;
      end
      if (!got_done) begin
         chk("R8", "watchdog: no done", 0, 1);
      end else begin
         chk(exp_to ? "R6" : "R1", "write count", nwr, exp_n);
         for (int k = 0; k < nwr && k < exp_n; k++) begin
            chk("R2", "write target", wr_tgt[k], t_tgt(d, k));
            chk("R2", "write mask", wr_mask[k], t_mask(d, k));
         end
         chk("R6", "timeout flag", int'(timeout_o), int'(exp_to));
         chk("R6", "error code", int'(err_code_o), exp_to ? 25 : 0);
         if (timing && nwr == exp_n) begin
            for (int k = 0; k + 1 < nwr; k++)
               chk(t_hr(d, k) ? "R4" : "R3", "write spacing",
                   wr_cyc[k+1] - wr_cyc[k], t_hr(d, k) ? 2 : 1);
            if (exp_to)
               chk("R5", "timeout latency", done_cyc - wr_cyc[nwr-1], TO_GAP);
            else
               chk("R3", "done latency", done_cyc - wr_cyc[nwr-1],
                   t_hr(d, nwr-1) ? 2 : 1);
         end
         @(negedge clk);
         chk("R8", "done one cycle", int'(done_o), 0);
      end
      logging = 0;
   endtask

   function automatic logic [NT*MW-1:0] rnd_rdy();
      logic [NT*MW-1:0] v;
      for (int g = 0; g < NT; g++) begin
         case ($urandom % 3)
            0: v[g*MW +: MW] = 8'($urandom);
            1: v[g*MW +: MW] = 8'hFF;
            default: v[g*MW +: MW] = 8'hFF ^ (8'h1 << ($urandom % 8));
         endcase
      end
      return v;
   endfunction

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R10", "busy in reset", int'(busy_o), 0);
      chk("R10", "strobes in reset", int'(en_wr_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10", "busy after reset", int'(busy_o), 0);
      chk("R10", "done after reset", int'(done_o), 0);
      chk("R10", "timeout after reset", int'(timeout_o), 0);
      chk("R10", "err after reset", int'(err_code_o), 0);
      chk("R10", "strobes after reset", int'(en_wr_o), 0);

      run(1'b0, '1, 0, 0, 1);                              // R7 power-down table
      run(1'b1, '1, 0, 0, 1);                              // R7 power-up table
      run(1'b0, 32'hFFFF_0EFF, 0, 0, 1);                   // R5 abort at step 0
      run(1'b0, 32'hC0FF_FFFF, 0, 0, 1);                   // R6 abort at last step
      run(1'b0, 32'hC100_0F00, 0, 0, 1);                   // R4 exact masks
      run(1'b1, 32'h0000_7E00 | 32'h0081_0000, 0, 0, 1);   // R4 exact, other lanes low
      repeat (6) @(negedge clk);
      run(1'b1, 32'h0080_0000, 0, 0, 1);                   // R6 power-up abort
      repeat (5) @(negedge clk);
      chk("R8", "timeout held while idle", int'(timeout_o), 1);
      chk("R6", "error held while idle", int'(err_code_o), 25);
      run(1'b0, 32'hFFFF_00FF, 1 + (NP - 1) * TK, 0, 0);   // R5 ready at final poll
      run(1'b0, 32'hFFFF_00FF, 2 + (NP - 1) * TK, 0, 0);   // R5 ready one cycle late
      run(1'b1, '1, 0, 1, 1);                              // R9 start while busy
      run(1'b0, 32'hFFFF_0EFF, 0, 1, 1);                   // R9 during a wait

      for (int i = 0; i < 40; i++) begin
         bit d = 1'($urandom % 2);
         run(d, rnd_rdy(), 0, 1'($urandom % 4 == 0), 1);
      end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule